// File: doc/BRIEF.md
# Dual-Channel Result Snapshot Lock

This block sits between two free-running conversion streams, one carrying current codes and one carrying voltage codes, and a byte-wide register read port. When a sample strobe arrives and the block is armed, both channel codes are latched together into a single snapshot. All four result bytes a host reads therefore belong to one sampling instant. The current code is clamped before capture, because the top of its range is not usable after offset calibration.

After a load the snapshot is frozen. It is released for the next load only once the host has read all four result bytes in strictly descending address order: current high, current low, voltage high, voltage low. A ready bit, readable at a status address, shows that a fresh snapshot is waiting. Reads at non-result addresses leave the order tracking untouched.

Top module: `snap_lock`

## Requirements
- R1: After reset, ready is 0, all four result addresses read 0x00, and the first sample strobe is accepted as a load.
- R2: One accepted strobe captures both channel codes in the same clock edge, so a following read sequence returns bytes from that single strobe.
- R3: Results are 12-bit codes, right-justified in 16 bits. The current high byte is at 0x0203 and its low byte at 0x0202. The voltage high byte is at 0x0201 and its low byte at 0x0200. Bits 7:4 of both high bytes read 0.
- R4: A current code above 3840 is stored as 3840 (bytes 0x0F, 0x00). A code of exactly 3840 is stored unchanged. Voltage codes up to 0x0FFF are stored unchanged.
- R5: After a load, later strobes are ignored until 0x0203, 0x0202, 0x0201 and 0x0200 have been read in that order. After that, the next strobe loads.
- R6: A read of a result address that is not the expected next one drops the sequence back to its start (unless it is 0x0203). An incomplete sequence leaves the old snapshot in place and blocks new loads.
- R7: A read of 0x0203 at any point restarts the sequence as its first step.
- R8: A read at 0x0103 returns 0 in bits 7:1 and the ready flag in bit 0. Ready is set by a load and cleared by a read of 0x0203. Other unmapped addresses read 0x00.
- R9: A strobe is not taken in a cycle that carries a result-address read, nor while a read sequence is part way through. The first strobe after the sequence completes with no read pending loads.
- R10: Reads of the status address or unmapped addresses in the middle of a sequence neither advance it nor break it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Both channel codes are valid this cycle |
| cur_code | input | 12 | Raw current channel code |
| vol_code | input | 12 | Raw voltage channel code |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 16 | Register read address |
| rd_data | output | 8 | Read data byte, combinational on rd_addr |
| ready | output | 1 | A fresh snapshot is loaded and unread |

## Verification
Two events can land in one cycle: a sample strobe and a result-address read, either the read that starts a sequence or one inside it. The bench provokes this with the block armed and the tracker idle. It raises the strobe in the same cycle as a read of 0x0203, and then again while the sequence is part way through. After each, it reads the bytes back to show that the old snapshot survived and that the read saw consistent data. It then completes the sequence and shows that the next lone strobe loads.

// File: rtl/snl_pkg.sv
package snl_pkg;
   typedef enum logic [1:0] {
      TRK_IDLE = 2'd0,
      TRK_CH   = 2'd1,
      TRK_CL   = 2'd2,
      TRK_VH   = 2'd3
   } trk_state_t;
endpackage

// File: rtl/snl_clamp.sv
module snl_clamp #(
   parameter int          CODE_W   = 12,
   parameter bit          CLIP_EN  = 1'b1,
   parameter logic [15:0] CLIP_MAX = 16'd3840
) (
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_out
);
   localparam logic [CODE_W-1:0] LIM = CLIP_MAX[CODE_W-1:0];

   generate
      if (CLIP_EN) begin : g_clip
         assign code_out = (code_in > LIM) ? LIM : code_in;
      end else begin : g_pass
         assign code_out = code_in;
      end
   endgenerate
endmodule

// File: rtl/snl_order_track.sv
module snl_order_track
   import snl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_en,
   input  logic [3:0] hit,
   output logic       idle,
   output logic       start,
   output logic       done
);
   trk_state_t state_q, state_d;
   logic       data_rd;

   assign data_rd = rd_en && (|hit);

   always_comb begin
      state_d = state_q;
      start   = 1'b0;
      done    = 1'b0;
      if (data_rd) begin
         if (hit[3]) begin
            state_d = TRK_CH;
            start   = 1'b1;
         end else if (state_q == TRK_CH && hit[2]) begin
            state_d = TRK_CL;
         end else if (state_q == TRK_CL && hit[1]) begin
            state_d = TRK_VH;
         end else if (state_q == TRK_VH && hit[0]) begin
            state_d = TRK_IDLE;
            done    = 1'b1;
         end else begin
            state_d = TRK_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TRK_IDLE;
      else        state_q <= state_d;
   end

   assign idle = (state_q == TRK_IDLE);

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)) else $error("hit not onehot0"); // R3
   AST_NONDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || hit == 4'b0) |=> $stable(state_q)) else $error("tracker moved"); // R10
endmodule

// File: rtl/snl_snapshot.sv
module snl_snapshot #(
   parameter int          CODE_W   = 12,
   parameter logic [15:0] CLIP_MAX = 16'd3840
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [CODE_W-1:0] cur_in,
   input  logic [CODE_W-1:0] vol_in,
   input  logic              trk_idle,
   input  logic              data_rd,
   input  logic              seq_start,
   input  logic              seq_done,
   output logic [CODE_W-1:0] cur_q,
   output logic [CODE_W-1:0] vol_q,
   output logic              ready
);
   logic armed_q;
   logic load;

   assign load = smp_valid && armed_q && trk_idle && !data_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= '0;
         vol_q   <= '0;
         armed_q <= 1'b1;
         ready   <= 1'b0;
      end else begin
         if (load) begin
            cur_q   <= cur_in;
            vol_q   <= vol_in;
            armed_q <= 1'b0;
            ready   <= 1'b1;
         end else begin
            if (seq_done)  armed_q <= 1'b1;
            if (seq_start) ready   <= 1'b0;
         end
      end
   end

   AST_CUR_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
      {{(16-CODE_W){1'b0}}, cur_q} <= CLIP_MAX) else $error("current above clip"); // R4
   AST_HOLD_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cur_q) || !$stable(vol_q)) |-> $past(armed_q)) else $error("load while locked"); // R5
   AST_READY_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(smp_valid)) else $error("ready without strobe"); // R8
   AST_NO_LOAD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd |=> ($stable(cur_q) && $stable(vol_q))) else $error("load during read"); // R9
endmodule

// File: rtl/snap_lock.sv
module snap_lock #(
   parameter int          CODE_W    = 12,
   parameter int          ADDR_W    = 16,
   parameter bit          CLIP_EN   = 1'b1,
   parameter logic [15:0] CUR_CLIP  = 16'd3840,
   parameter logic [15:0] A_CUR_HI  = 16'h0203,
   parameter logic [15:0] A_CUR_LO  = 16'h0202,
   parameter logic [15:0] A_VOL_HI  = 16'h0201,
   parameter logic [15:0] A_VOL_LO  = 16'h0200,
   parameter logic [15:0] A_STATUS  = 16'h0103
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [CODE_W-1:0] cur_code,
   input  logic [CODE_W-1:0] vol_code,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              ready
);
   localparam int PAD_W = 16 - CODE_W;

   initial begin
      if (CODE_W < 9 || CODE_W > 16) $error("CODE_W must be 9..16");
      if (ADDR_W < 16) $error("ADDR_W must be at least 16");
   end

   logic [CODE_W-1:0] cur_clip;
   logic [CODE_W-1:0] cur_q, vol_q;
   logic [3:0]        hit;
   logic              hit_stat;
   logic              trk_idle, seq_start, seq_done, data_rd;
   logic [15:0]       cur_w, vol_w;

   snl_clamp #(.CODE_W(CODE_W), .CLIP_EN(CLIP_EN), .CLIP_MAX(CUR_CLIP)) u_clamp (
      .code_in (cur_code),
      .code_out(cur_clip)
   );

   assign hit[3]   = (rd_addr == ADDR_W'(A_CUR_HI));
   assign hit[2]   = (rd_addr == ADDR_W'(A_CUR_LO));
   assign hit[1]   = (rd_addr == ADDR_W'(A_VOL_HI));
   assign hit[0]   = (rd_addr == ADDR_W'(A_VOL_LO));
   assign hit_stat = (rd_addr == ADDR_W'(A_STATUS));
   assign data_rd  = rd_en && (|hit);

   snl_order_track u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_en(rd_en),
      .hit  (hit),
      .idle (trk_idle),
      .start(seq_start),
      .done (seq_done)
   );

   snl_snapshot #(.CODE_W(CODE_W), .CLIP_MAX(CUR_CLIP)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .cur_in   (cur_clip),
      .vol_in   (vol_code),
      .trk_idle (trk_idle),
      .data_rd  (data_rd),
      .seq_start(seq_start),
      .seq_done (seq_done),
      .cur_q    (cur_q),
      .vol_q    (vol_q),
      .ready    (ready)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign cur_w = {{PAD_W{1'b0}}, cur_q};
         assign vol_w = {{PAD_W{1'b0}}, vol_q};
      end else begin : g_nopad
         assign cur_w = cur_q;
         assign vol_w = vol_q;
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      if      (hit[3])   rd_data = cur_w[15:8];
      else if (hit[2])   rd_data = cur_w[7:0];
      else if (hit[1])   rd_data = vol_w[15:8];
      else if (hit[0])   rd_data = vol_w[7:0];
      else if (hit_stat) rd_data = {7'b0, ready};
   end

   AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit_stat) |-> (rd_data[7:1] == 7'b0 && rd_data[0] == ready)) else $error("status bad"); // R8
   AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit[3]) |=> !ready) else $error("ready kept after start"); // R8
endmodule

// File: tb/snap_lock_bench.sv
module snap_lock_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] cur_code = '0;
   logic [11:0] vol_code = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_addr = '0;
   logic [7:0]  rd_data;
   logic        ready;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   snap_lock u_snap_lock (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .cur_code(cur_code), .vol_code(vol_code),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   // one read cycle; data sampled before the edge, tracker updates at the edge
   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #2 chk(tag, rd_data, exp);
      @(negedge clk);
      rd_en = 1'b0; rd_addr = '0;
   endtask

   task automatic smp(input logic [11:0] c, input logic [11:0] v);
      @(negedge clk);
      smp_valid = 1'b1; cur_code = c; vol_code = v;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic seq(input logic [11:0] c, input logic [11:0] v, input string tag);
      rd(16'h0203, {4'h0, c[11:8]}, tag);
      rd(16'h0202, c[7:0], tag);
      rd(16'h0201, {4'h0, v[11:8]}, tag);
      rd(16'h0200, v[7:0], tag);
   endtask

   task automatic t_reset;
      chk("R1 ready", {7'b0, ready}, 8'h00);
      rd(16'h0203, 8'h00, "R1 cur hi");
      rd(16'h0202, 8'h00, "R1 cur lo");
      rd(16'h0201, 8'h00, "R1 vol hi");
      rd(16'h0200, 8'h00, "R1 vol lo");
      rd(16'h0103, 8'h00, "R1 status");
   endtask

   task automatic t_first;
      smp(12'hABC, 12'h123);
      rd(16'h0103, 8'h01, "R8 status set");
      seq(12'hABC, 12'h123, "R2 R3 coherent");
      rd(16'h0103, 8'h00, "R8 status cleared");
      rd(16'h1234, 8'h00, "R8 unmapped");
   endtask

   task automatic t_clamp;
      smp(12'hFFF, 12'hFFF);
      seq(12'hF00, 12'hFFF, "R4 clip max");
      smp(12'hF01, 12'h000);
      seq(12'hF00, 12'h000, "R4 clip 3841");
      smp(12'hF00, 12'h800);
      seq(12'hF00, 12'h800, "R4 exact 3840");
   endtask

   task automatic t_lock;
      smp(12'h111, 12'h222);
      smp(12'h333, 12'h444);
      rd(16'h0203, 8'h01, "R5 locked hi");
      rd(16'h0202, 8'h11, "R5 locked lo");
      rd(16'h0200, 8'h22, "R6 skip read");
      smp(12'h555, 12'h666);
      rd(16'h0201, 8'h02, "R6 stray");
      rd(16'h0200, 8'h22, "R6 stray2");
      smp(12'h555, 12'h666);
      seq(12'h111, 12'h222, "R6 old kept");
      smp(12'h777, 12'h888);
      seq(12'h777, 12'h888, "R5 new after seq");
   endtask

   task automatic t_restart;
      rd(16'h0203, 8'h07, "R7 first");
      rd(16'h0202, 8'h77, "R7 first lo");
      seq(12'h777, 12'h888, "R7 restart");
      smp(12'h9AB, 12'hCDE);
      seq(12'h9AB, 12'hCDE, "R7 loaded");
   endtask

   task automatic t_nondata;
      rd(16'h0203, 8'h09, "R10 hi");
      rd(16'h0103, 8'h00, "R10 status");
      rd(16'h0005, 8'h00, "R10 unmapped");
      rd(16'h0202, 8'hAB, "R10 lo");
      rd(16'h0201, 8'h0C, "R10 vhi");
      rd(16'h0200, 8'hDE, "R10 vlo");
      smp(12'h0F0, 12'h00F);
      seq(12'h0F0, 12'h00F, "R10 loaded");
   endtask

   task automatic t_collide;
      @(negedge clk);
      smp_valid = 1'b1; cur_code = 12'h246; vol_code = 12'h8AC;
      rd_en = 1'b1; rd_addr = 16'h0203;
      #2 chk("R9 same-cycle read", rd_data, 8'h00);
      @(negedge clk);
      rd_en = 1'b0; smp_valid = 1'b0;
      rd(16'h0202, 8'hF0, "R9 mid");
      smp(12'h246, 12'h8AC);
      rd(16'h0201, 8'h00, "R9 vhi");
      rd(16'h0200, 8'h0F, "R9 vlo");
      rd(16'h0103, 8'h00, "R9 no load");
      smp(12'h246, 12'h8AC);
      rd(16'h0103, 8'h01, "R9 later load");
      seq(12'h246, 12'h8AC, "R9 data");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_first;
      t_clamp;
      t_lock;
      t_restart;
      t_nondata;
      t_collide;
      done_flag = 1'b1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule